// File: doc/BRIEF.md
# Ethernet Destination Address Filter with Multicast Hash

This block sits on a MAC's receive path and decides, per frame, whether the frame is kept or dropped. It watches the first six bytes of each frame (the destination address) as they stream past on a byte-wide bus. While the bytes arrive it folds them into a reflected CRC-32. The top bits of the complemented, bit-reversed CRC then index a programmable table of hash bins. In parallel, the address is compared against a small bank of exact-match address entries. The verdict is a single-cycle pulse with an accept flag.

Software sets the filter through a plain write port. It writes a mode word, the hash table words and the exact-match entries. The filter takes a snapshot of all of these at each start of frame, so reprogramming never changes the treatment of a frame already in flight. The number of hash bins (64, 128 or 256) and the number of exact-match entries are build-time parameters.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash bin of an address is formed by running a reflected CRC-32 (polynomial 0xEDB88320, seed all ones, each byte fed least-significant bit first) over the six address bytes in arrival order. The result is complemented and bit-reversed, and the top log2(HASH_BINS) bits are taken.
- R2: The table is held as HASH_BINS/32 words of 32 bits, written at addresses 0x010 + word. Bin index bits above bit 4 choose the word and bits 4:0 choose the bit within it, so setting the same bit position in another word does not hit.
- R3: An address is multicast when bit 0 of its first byte is 1. With the mode word (address 0x000) bit 2 (hash enable) set and bit 3 clear, a non-broadcast multicast frame is accepted only if its table bit is set.
- R4: With mode bit 1 (pass all multicast) set, every multicast frame is accepted regardless of the table.
- R5: With mode bit 0 (promiscuous) set, every frame is accepted, including broadcast with broadcast rejection enabled.
- R6: Exact-match entry k is written at 0x100 + 2k (address bytes 0..3, byte 0 in bits 7:0) and 0x101 + 2k (bytes 4..5 in bits 15:0). Entry 0 resets to PRIMARY_MAC and is always live. Any other entry that is all zero never matches. A unicast frame is accepted exactly when an entry matches.
- R7: With hash enable and mode bit 3 (hash or exact) both set, a multicast frame is accepted when either its table bit is set or an entry matches.
- R8: With hash enable clear, a multicast frame is accepted only when an entry matches, and unicast frames never consult the table.
- R9: The all-ones address is accepted unless mode bit 4 (broadcast reject) is set, in which case it is dropped.
- R10: res_valid is a one-cycle pulse on the clock edge after the sixth address byte is taken. res_accept is low whenever res_valid is low. Idle cycles between bytes are allowed. Bytes after the sixth are ignored. A new rx_sof restarts address capture.
- R11: Writes that land while a frame is being captured affect only frames whose rx_sof comes after the write.
- R12: After reset the mode word and all table bits are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| rx_valid | input | 1 | Byte strobe for rx_data |
| rx_data | input | 8 | Received byte |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register write address |
| wr_data | input | 32 | Register write data |
| res_valid | output | 1 | Verdict pulse for the current frame |
| res_accept | output | 1 | Frame accepted, meaningful while res_valid is high |

## Verification
The verdict is registered once. It must appear exactly on the edge that takes the sixth byte, be visible at the following falling edge, and be gone one cycle later. The bench drives each byte at a falling edge and watches every falling edge before the sixth byte for a premature pulse. It samples the verdict at the first falling edge after the sixth byte and confirms at the next one that the pulse has ended. Register writes take effect at the next rx_sof, so every vector programs the filter between frames. One directed case instead writes in the middle of a frame and expects the old mode to hold for that frame.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam int          ADDR_BYTES    = 6;

    // Mode word, bit 0 at the bottom
    typedef struct packed {
        logic bcast_rej;    // bit 4
        logic hash_or_ex;   // bit 3
        logic hash_en;      // bit 2
        logic pass_mc;      // bit 1
        logic promisc;      // bit 0
    } mode_t;

    // One byte through the reflected CRC-32, LSB first
    function automatic logic [31:0] crc_feed_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY_REFL;
        end
        return r;
    endfunction

endpackage

// File: rtl/mhf_hash_lookup.sv
module mhf_hash_lookup #(
    parameter int HASH_BINS = 64,
    localparam int IDX_W    = $clog2(HASH_BINS),
    localparam int WORDS    = HASH_BINS / 32
) (
    input  logic [IDX_W-1:0]     crc_low,
    input  logic [HASH_BINS-1:0] table_bits,
    output logic                 hit
);
    // Complement then reverse: bin bit k is the inverse of crc bit IDX_W-1-k
    logic [IDX_W-1:0]      bin;
    logic [WORDS-1:0][31:0] words;
    logic [31:0]           sel_word;

    always_comb begin
        for (int k = 0; k < IDX_W; k++) begin
            bin[k] = ~crc_low[IDX_W-1-k];
        end
    end

    assign words    = table_bits;
    assign sel_word = words[bin[IDX_W-1:5]];
    assign hit      = sel_word[bin[4:0]];

endmodule

// File: rtl/mhf_exact_match.sv
module mhf_exact_match #(
    parameter int N_ENTRIES = 4
) (
    input  logic [N_ENTRIES-1:0][47:0] entries,
    input  logic [47:0]                dst,
    output logic                       hit
);
    logic [N_ENTRIES-1:0] match;

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
        if (k == 0) begin : g_primary
            assign match[k] = (entries[k] == dst);
        end else begin : g_other
            assign match[k] = (|entries[k]) && (entries[k] == dst);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int          HASH_BINS   = 64,
    parameter int          N_PERFECT   = 4,
    parameter logic [47:0] PRIMARY_MAC = 48'hCCBBAA000002
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        wr_en,
    input  logic [8:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        res_valid,
    output logic        res_accept
);
    localparam int IDX_W      = $clog2(HASH_BINS);
    localparam int HASH_WORDS = HASH_BINS / 32;
    localparam int LAST_POS   = ADDR_BYTES - 1;

    typedef struct packed {
        mode_t                      mode_sh;
        mode_t                      mode_act;
        logic [HASH_BINS-1:0]       hash_sh;
        logic [HASH_BINS-1:0]       hash_act;
        logic [N_PERFECT-1:0][47:0] ent_sh;
        logic [N_PERFECT-1:0][47:0] ent_act;
        logic                       busy;
        logic [2:0]                 cnt;
        logic [31:0]                crc;
        logic [47:0]                dst;
        logic                       res_valid;
        logic                       res_accept;
    } state_t;

    state_t s_d, s_q;

    logic [2:0]  pos;
    logic [31:0] crc_nx;
    logic [47:0] dst_nx;
    logic        hash_hit;
    logic        exact_hit;
    logic        verdict;

    // Next CRC and address with the incoming byte folded in
    always_comb begin
        pos    = rx_sof ? 3'd0 : s_q.cnt;
        crc_nx = crc_feed_byte(rx_sof ? 32'hFFFF_FFFF : s_q.crc, rx_data);
        dst_nx = rx_sof ? 48'h0 : s_q.dst;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (pos == 3'(k)) dst_nx[8*k +: 8] = rx_data;
        end
    end

    mhf_hash_lookup #(.HASH_BINS(HASH_BINS)) u_hash (
        .crc_low   (crc_nx[IDX_W-1:0]),
        .table_bits(s_q.hash_act),
        .hit       (hash_hit)
    );

    mhf_exact_match #(.N_ENTRIES(N_PERFECT)) u_exact (
        .entries(s_q.ent_act),
        .dst    (dst_nx),
        .hit    (exact_hit)
    );

    // Verdict for the address completed by this byte
    always_comb begin
        if (s_q.mode_act.promisc) begin
            verdict = 1'b1;
        end else if (&dst_nx) begin
            verdict = !s_q.mode_act.bcast_rej;
        end else if (dst_nx[0]) begin
            if (s_q.mode_act.pass_mc)      verdict = 1'b1;
            else if (s_q.mode_act.hash_en) verdict = hash_hit || (s_q.mode_act.hash_or_ex && exact_hit);
            else                           verdict = exact_hit;
        end else begin
            verdict = exact_hit;
        end
    end

    always_comb begin
        s_d            = s_q;
        s_d.res_valid  = 1'b0;
        s_d.res_accept = 1'b0;

        if (wr_en) begin
            if (wr_addr == 9'h000) s_d.mode_sh = mode_t'(wr_data[4:0]);
            for (int i = 0; i < HASH_WORDS; i++) begin
                if (wr_addr == 9'(16 + i)) s_d.hash_sh[32*i +: 32] = wr_data;
            end
            for (int k = 0; k < N_PERFECT; k++) begin
                if (wr_addr[8] && wr_addr[7:1] == 7'(k)) begin
                    if (wr_addr[0]) s_d.ent_sh[k][47:32] = wr_data[15:0];
                    else            s_d.ent_sh[k][31:0]  = wr_data;
                end
            end
        end

        if (rx_valid && rx_sof) begin
            s_d.mode_act = s_q.mode_sh;
            s_d.hash_act = s_q.hash_sh;
            s_d.ent_act  = s_q.ent_sh;
            s_d.crc      = crc_nx;
            s_d.dst      = dst_nx;
            s_d.cnt      = 3'd1;
            s_d.busy     = 1'b1;
        end else if (rx_valid && s_q.busy) begin
            s_d.crc = crc_nx;
            s_d.dst = dst_nx;
            s_d.cnt = s_q.cnt + 3'd1;
            if (s_q.cnt == 3'(LAST_POS)) begin
                s_d.busy       = 1'b0;
                s_d.res_valid  = 1'b1;
                s_d.res_accept = verdict;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.ent_sh[0]  <= PRIMARY_MAC;
            s_q.ent_act[0] <= PRIMARY_MAC;
        end else begin
            s_q <= s_d;
        end
    end

    assign res_valid  = s_q.res_valid;
    assign res_accept = s_q.res_accept;

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker
    import mhf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        res_valid,
    input logic        res_accept,
    input mode_t       mode,
    input logic [47:0] dst
);
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R10
    accept_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_accept);

    // R10
    byte_then_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rx_valid));

    // R5
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mode.promisc) |-> res_accept);

    // R9
    bcast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !mode.promisc && (&dst) && !mode.bcast_rej) |-> res_accept);

    // R9
    bcast_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !mode.promisc && (&dst) && mode.bcast_rej) |-> !res_accept);

    // R4
    pass_mc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !mode.promisc && mode.pass_mc && dst[0] && !(&dst)) |-> res_accept);

endmodule

bind mcast_hash_filter mhf_checker u_mhf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .res_valid (res_valid),
    .res_accept(res_accept),
    .mode      (s_q.mode_act),
    .dst       (s_q.dst)
);

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;

    localparam logic [47:0] PRIM  = 48'hCCBBAA000002;
    localparam logic [47:0] U1    = 48'h554433221102;
    localparam logic [47:0] U2    = 48'h556677889902;
    localparam logic [47:0] M1    = 48'hFB00005E0001;
    localparam logic [47:0] M2    = 48'h010000003333;
    localparam logic [47:0] BC    = 48'hFFFFFFFFFFFF;
    localparam int          BINS  = 64;
    localparam int          NWORD = BINS / 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = 9'h0;
    logic [31:0] wr_data = 32'h0;
    logic        res_valid;
    logic        res_accept;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mcast_hash_filter dut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .res_valid(res_valid), .res_accept(res_accept)
    );

    // mode bits: [4] bcast reject, [3] hash-or-exact, [2] hash, [1] pass mcast, [0] promisc
    // hsel: 0 table clear, 1 table full, 2 own bin only, 3 same bit in the other word only
    typedef struct packed {
        logic [4:0]  mode;
        logic [1:0]  hsel;
        logic [47:0] addr;
        logic        exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{5'b00000, 2'd0, PRIM, 1'b1},  // R6 primary entry
        '{5'b00000, 2'd0, U1,   1'b1},  // R6 programmed entry
        '{5'b00000, 2'd0, U2,   1'b0},  // R6 no entry
        '{5'b00000, 2'd0, M1,   1'b0},  // R8 mcast, no entry
        '{5'b00100, 2'd2, M1,   1'b1},  // R1 R3 own bin set
        '{5'b00100, 2'd3, M1,   1'b0},  // R2 wrong word
        '{5'b00010, 2'd0, M1,   1'b1},  // R4 pass all
        '{5'b00001, 2'd0, U2,   1'b1},  // R5 promisc
        '{5'b00000, 2'd0, BC,   1'b1},  // R9 broadcast
        '{5'b10000, 2'd0, BC,   1'b0},  // R9 broadcast rejected
        '{5'b10001, 2'd0, BC,   1'b1},  // R5 promisc over reject
        '{5'b00100, 2'd0, M2,   1'b0},  // R3 entry ignored under hash
        '{5'b01100, 2'd0, M2,   1'b1},  // R7 hash or exact
        '{5'b00000, 2'd0, M2,   1'b1},  // R8 mcast by entry
        '{5'b00100, 2'd1, U2,   1'b0}   // R8 unicast skips table
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 2:  return "R6";
            3, 13, 14: return "R8";
            4:        return "R1";
            5:        return "R2";
            6:        return "R4";
            7, 10:    return "R5";
            8, 9:     return "R9";
            11:       return "R3";
            default:  return "R7";
        endcase
    endfunction

    function automatic int bench_bin(input logic [47:0] a);
        logic [31:0] c;
        logic [31:0] r;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            fb = c[0] ^ a[k];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        c = ~c;
        for (int j = 0; j < 32; j++) r[j] = c[31-j];
        return int'(r >> (32 - $clog2(BINS)));
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_frame(input logic [47:0] a, input int gap,
                              output bit v, output bit acc, output bit early, output bit late);
        early = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (k > 0) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    if (res_valid) early = 1'b1;
                    rx_valid = 1'b0; rx_sof = 1'b0;
                end
            end
            @(negedge clk);
            if (res_valid) early = 1'b1;
            rx_valid = 1'b1; rx_sof = (k == 0); rx_data = a[8*k +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        v = res_valid; acc = res_accept;
        @(negedge clk);
        late = res_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit v, acc, early, late;
        int b;
        logic [31:0] w;

        repeat (3) @(negedge clk);
        // R12 outputs low in reset and just after
        check(!res_valid && !res_accept, "R12", {res_valid, res_accept}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!res_valid && !res_accept, "R12", {res_valid, res_accept}, 0);

        // R12 clear modes and table: multicast dropped
        send_frame(M1, 0, v, acc, early, late);
        check(v && !acc && !early && !late, "R12", {v, acc, early, late}, 4'b1000);
        // R6 primary entry live after reset
        send_frame(PRIM, 0, v, acc, early, late);
        check(v && acc && !early && !late, "R6", {v, acc, early, late}, 4'b1100);
        // R6 zero entries never match the zero address
        send_frame(48'h0, 0, v, acc, early, late);
        check(v && !acc, "R6", {v, acc}, 2'b10);

        wr(9'h102, U1[31:0]);  wr(9'h103, {16'h0, U1[47:32]});
        wr(9'h104, M2[31:0]);  wr(9'h105, {16'h0, M2[47:32]});

        for (int i = 0; i < NV; i++) begin
            wr(9'h000, {27'h0, VECS[i].mode});
            b = bench_bin(VECS[i].addr);
            for (int wi = 0; wi < NWORD; wi++) begin
                case (VECS[i].hsel)
                    2'd0: w = 32'h0;
                    2'd1: w = 32'hFFFF_FFFF;
                    2'd2: w = (wi == (b >> 5)) ? (32'h1 << (b & 31)) : 32'h0;
                    default: w = (wi == ((b >> 5) ^ 1)) ? (32'h1 << (b & 31)) : 32'h0;
                endcase
                wr(9'(16 + wi), w);
            end
            send_frame(VECS[i].addr, 0, v, acc, early, late);
            check(v && (acc == VECS[i].exp) && !early && !late, vec_req(i),
                  {v, acc, early, late}, {1'b1, VECS[i].exp, 2'b00});
        end

        wr(9'h000, 32'h0);
        wr(9'h010, 32'h0);
        wr(9'h011, 32'h0);

        // R10 idle cycles between bytes
        send_frame(U1, 2, v, acc, early, late);
        check(v && acc && !early && !late, "R10", {v, acc, early, late}, 4'b1100);

        // R10 bytes beyond the sixth give no result
        early = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (res_valid) early = 1'b1;
            rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hFF;
        end
        @(negedge clk);
        if (res_valid) early = 1'b1;
        rx_valid = 1'b0;
        @(negedge clk);
        if (res_valid) early = 1'b1;
        check(!early, "R10", early, 0);

        // R10 rx_sof restarts capture of the address
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_data = U2[8*k +: 8];
        end
        send_frame(PRIM, 0, v, acc, early, late);
        check(v && acc && !early && !late, "R10", {v, acc, early, late}, 4'b1100);

        // R11 promisc written mid-frame does not touch that frame
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_data = U2[8*k +: 8];
            wr_en = (k == 3); wr_addr = 9'h000; wr_data = 32'h1;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; wr_en = 1'b0;
        v = res_valid; acc = res_accept;
        check(v && !acc, "R11", {v, acc}, 2'b10);
        // R11 next frame sees it
        send_frame(U2, 0, v, acc, early, late);
        check(v && acc, "R11", {v, acc}, 2'b11);
        wr(9'h000, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule